// File: doc/BRIEF.md
# Flash Cache Control and Flush Sequencer

This block is the control register file for an execute-in-place flash cache. It holds the control bits that the cache datapath reads: cache enable, a fault-on-bad-write flag and power-down. It also runs the tag flush and keeps two saturating performance counters, one for hits and one for total accesses. Software reaches it over a simple word-addressed register bus. Reads complete in the cycle they are presented unless the bus is held by the stall output. Writes always complete in one cycle.

A flush walks the tag memory one index per clock and pulses a clear write-enable for each index. The data memory is never touched. A flush is requested by software through the flush register, and one also starts by itself when reset is released. While a flush is pending, a read of the flush register stalls the bus, so a program can wait for completion with a single load. It can instead poll the status register. The cache datapath supplies single-cycle hit and access strobes. The streaming FIFO supplies its empty and full flags, which are reported in the status register.

Top module: `xcc_top`

## Requirements
- R1: The control register at word address 0 stores write data bit 0 as enable, bit 1 as bad-write fault and bit 3 as power-down. It reads back as {28'b0, powerDown, 1'b0, badWriteFault, cacheEn}, with all other bits reading 0, and its fields drive the ports of the same names.
- R2: A control write with bit 3 set leaves the enable bit at 0 whatever bit 0 holds, so cacheEn is never 1 while powerDown is 1.
- R3: A write to word address 1 with data bit 0 set starts a flush in the next cycle. tagClrWe is then high for exactly DEPTH consecutive cycles, with tagClrIdx going 0, 1, ..., DEPTH-1. A write to the same address with bit 0 clear starts nothing.
- R4: A flush starts by itself on reset release. In the first cycle after reset, tagClrWe is 1 with index 0, and the walk runs through all DEPTH indices.
- R5: The status register at word address 2 reads {29'b0, fifoFull, fifoEmpty, ready}, where ready is 0 while a flush is running and 1 otherwise.
- R6: A read of word address 1 holds busStall high while a flush is running and completes in the first cycle with no flush running. It returns 0. No other access stalls.
- R7: A flush request that arrives during a flush restarts the walk at index 0 in the next cycle, and a full DEPTH-cycle walk follows.
- R8: The hit counter at word address 3 counts the cycles in which hitStrobe is high. It stops at all ones, and any write to it clears it to 0 without affecting the access counter.
- R9: The access counter at word address 4 counts the cycles in which accessStrobe is high, whether or not hitStrobe is high. It stops at all ones, and any write to it clears it to 0.
- R10: After reset, the control register and both counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Register access request, held while busStall is high |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 3 | Word address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid when busSel is high and busStall is low |
| busStall | output | 1 | Holds the current read |
| hitStrobe | input | 1 | One cycle per cache hit |
| accessStrobe | input | 1 | One cycle per cache access of any kind |
| fifoEmpty | input | 1 | Streaming FIFO empty flag |
| fifoFull | input | 1 | Streaming FIFO full flag |
| tagClrIdx | output | IDX_W | Tag index being cleared |
| tagClrWe | output | 1 | Tag clear write-enable |
| cacheEn | output | 1 | Cache enable |
| badWriteFault | output | 1 | Fault on writes to non-allocating aliases |
| powerDown | output | 1 | Cache memories powered down |

## Verification
The flush walker is exercised in three ways: the walk started by reset, a walk started by a software write, and a second request made two cycles into a walk. The restart case is the only one that separates a walker that restarts at index 0 from one that keeps counting from where it was. A read of the flush register is made right after a request, where it must stall for DEPTH-1 cycles, and again when the block is idle, where it must not stall. This shows that the stall depends on the walk and not on the address alone. The counters are driven with hit and access strobes together, with accesses alone, and for long enough to reach the saturation limit. Clearing one counter with the other left at a known non-zero value shows that each clear acts only on its own counter.

// File: rtl/xcc_pkg.sv
package xcc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_FLUSH  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_HITS   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_ACCS   = 3'd4;

  // Single-cycle strobes from register control to the datapath
  typedef struct packed {
    logic flushStart;
    logic clrHit;
    logic clrAcc;
  } ctlStrobe_t;
endpackage

// File: rtl/xcc_ctrl.sv
module xcc_ctrl
  import xcc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busStall,
  input  logic              fifoEmpty,
  input  logic              fifoFull,
  input  logic              flushBusy,
  input  logic [CNT_W-1:0]  hitCnt,
  input  logic [CNT_W-1:0]  accCnt,
  output ctlStrobe_t        strb,
  output logic              cacheEn,
  output logic              badWriteFault,
  output logic              powerDown
);
  logic wrEn;
  logic rdEn;

  assign wrEn = busSel && busWrite;
  assign rdEn = busSel && !busWrite;

  assign strb.flushStart = wrEn && (busAddr == ADR_FLUSH) && busWdata[0];
  assign strb.clrHit     = wrEn && (busAddr == ADR_HITS);
  assign strb.clrAcc     = wrEn && (busAddr == ADR_ACCS);

  // Control bits; power-down wins over enable within one write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cacheEn       <= 1'b0;
      badWriteFault <= 1'b0;
      powerDown     <= 1'b0;
    end else if (wrEn && (busAddr == ADR_CTRL)) begin
      cacheEn       <= busWdata[0] && !busWdata[3];
      badWriteFault <= busWdata[1];
      powerDown     <= busWdata[3];
    end
  end

  assign busStall = rdEn && (busAddr == ADR_FLUSH) && flushBusy;

  always_comb begin
    busRdata = '0;
    if (rdEn) begin
      unique case (busAddr)
        ADR_CTRL:   busRdata = {28'b0, powerDown, 1'b0, badWriteFault, cacheEn};
        ADR_STATUS: busRdata = {29'b0, fifoFull, fifoEmpty, !flushBusy};
        ADR_HITS:   busRdata = DATA_W'(hitCnt);
        ADR_ACCS:   busRdata = DATA_W'(accCnt);
        default:    busRdata = '0;
      endcase
    end
  end

  assert_pd_blocks_en_R2: assert property (@(posedge clk) disable iff (!rstN)
    cacheEn |-> !powerDown);

  assert_ctrl_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (busAddr == ADR_CTRL)) |=> $stable(badWriteFault) && $stable(powerDown));
endmodule

// File: rtl/xcc_dp.sv
module xcc_dp
  import xcc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strb,
  input  logic             hitStrobe,
  input  logic             accessStrobe,
  output logic             flushBusy,
  output logic [IDX_W-1:0] tagClrIdx,
  output logic             tagClrWe,
  output logic [CNT_W-1:0] hitCnt,
  output logic [CNT_W-1:0] accCnt
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] walkIdx;

  // Busy from reset: the first cycle out of reset clears index 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flushBusy <= 1'b1;
      walkIdx   <= '0;
    end else if (strb.flushStart) begin
      flushBusy <= 1'b1;
      walkIdx   <= '0;
    end else if (flushBusy) begin
      if (walkIdx == LAST_IDX) begin
        flushBusy <= 1'b0;
        walkIdx   <= '0;
      end else begin
        walkIdx <= walkIdx + 1'b1;
      end
    end
  end

  assign tagClrWe  = flushBusy;
  assign tagClrIdx = walkIdx;

  // Two identical saturating counters
  logic [CNT_W-1:0] cnt [2];
  logic             incr [2];
  logic             clr  [2];

  assign incr[0] = hitStrobe;
  assign incr[1] = accessStrobe;
  assign clr[0]  = strb.clrHit;
  assign clr[1]  = strb.clrAcc;

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          cnt[g] <= '0;
      else if (clr[g])                    cnt[g] <= '0;
      else if (incr[g] && (cnt[g] != '1)) cnt[g] <= cnt[g] + 1'b1;
    end

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
      (cnt[g] == '1 && !clr[g]) |=> (cnt[g] == '1));

    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rstN)
      (incr[g] && !clr[g] && cnt[g] != '1) |=> (cnt[g] == $past(cnt[g]) + 1'b1));

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
      clr[g] |=> (cnt[g] == '0));
  end

  assign hitCnt = cnt[0];
  assign accCnt = cnt[1];

  assert_walk_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tagClrWe && !strb.flushStart && tagClrIdx != LAST_IDX) |=>
      (tagClrWe && tagClrIdx == IDX_W'($past(tagClrIdx) + 1'b1)));

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.flushStart |=> (tagClrWe && tagClrIdx == '0));

  assert_reset_flush_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (tagClrWe && tagClrIdx == '0));
endmodule

// File: rtl/xcc_top.sv
module xcc_top
  import xcc_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busStall,
  input  logic              hitStrobe,
  input  logic              accessStrobe,
  input  logic              fifoEmpty,
  input  logic              fifoFull,
  output logic [IDX_W-1:0]  tagClrIdx,
  output logic              tagClrWe,
  output logic              cacheEn,
  output logic              badWriteFault,
  output logic              powerDown
);
  ctlStrobe_t       strb;
  logic             flushBusy;
  logic [CNT_W-1:0] hitCnt;
  logic [CNT_W-1:0] accCnt;

  xcc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busStall(busStall),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .flushBusy(flushBusy),
    .hitCnt(hitCnt), .accCnt(accCnt), .strb(strb),
    .cacheEn(cacheEn), .badWriteFault(badWriteFault), .powerDown(powerDown)
  );

  xcc_dp #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hitStrobe(hitStrobe), .accessStrobe(accessStrobe),
    .flushBusy(flushBusy), .tagClrIdx(tagClrIdx), .tagClrWe(tagClrWe),
    .hitCnt(hitCnt), .accCnt(accCnt)
  );

  assert_stall_walk_R6: assert property (@(posedge clk) disable iff (!rstN)
    busStall |-> tagClrWe);
endmodule

// File: tb/xcc_top_tb.sv
module xcc_top_tb;
  localparam int DEPTH = 8;
  localparam int CNT_W = 8;
  localparam int IDX_W = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busSel = 1'b0;
  logic              busWrite = 1'b0;
  logic [2:0]        busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic              busStall;
  logic              hitStrobe = 1'b0;
  logic              accessStrobe = 1'b0;
  logic              fifoEmpty = 1'b0;
  logic              fifoFull = 1'b0;
  logic [IDX_W-1:0]  tagClrIdx;
  logic              tagClrWe;
  logic              cacheEn;
  logic              badWriteFault;
  logic              powerDown;

  int nChecks = 0;
  int nFails  = 0;

  logic [31:0] expData [$];
  string       expTag  [$];

  always #2 clk = ~clk;

  xcc_top #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busStall(busStall), .hitStrobe(hitStrobe), .accessStrobe(accessStrobe),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .tagClrIdx(tagClrIdx),
    .tagClrWe(tagClrWe), .cacheEn(cacheEn), .badWriteFault(badWriteFault),
    .powerDown(powerDown)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expectation per completed read
  always @(negedge clk) begin
    if (rstN && busSel && !busWrite && !busStall) begin
      if (expData.size() == 0) begin
        chk("read without expectation", busRdata, 32'hx);
      end else begin
        chk(expTag.pop_front(), busRdata, expData.pop_front());
      end
    end
  end

  task automatic busWr(logic [2:0] a, logic [31:0] d);
    @(posedge clk); #1;
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(logic [2:0] a, logic [31:0] exp, string tag, output int stalls);
    expData.push_back(exp);
    expTag.push_back(tag);
    stalls = 0;
    @(posedge clk); #1;
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    forever begin
      @(negedge clk);
      if (!busStall) break;
      stalls++;
    end
    @(posedge clk); #1;
    busSel = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    int s;
    busRd(a, exp, tag, s);
  endtask

  // Call at the negedge where index 0 is expected
  task automatic walkCheck(string tag);
    for (int k = 0; k < DEPTH; k++) begin
      chk({tag, " walk we"}, 32'(tagClrWe), 32'd1);
      chk({tag, " walk idx"}, 32'(tagClrIdx), 32'(k));
      @(negedge clk);
    end
    chk({tag, " walk ends"}, 32'(tagClrWe), 32'd0);
  endtask

  task automatic pulse(logic h, logic a, int n);
    @(posedge clk); #1;
    hitStrobe = h; accessStrobe = a;
    repeat (n) @(posedge clk);
    #1;
    hitStrobe = 1'b0; accessStrobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int s;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    walkCheck("R4 reset flush");

    rd(3'd0, 32'h0, "R10 ctrl reset");
    rd(3'd3, 32'h0, "R10 hit reset");
    rd(3'd4, 32'h0, "R10 acc reset");

    fifoEmpty = 1'b1; fifoFull = 1'b0;
    rd(3'd2, 32'h3, "R5 status empty ready");
    fifoEmpty = 1'b0; fifoFull = 1'b1;
    rd(3'd2, 32'h5, "R5 status full ready");
    fifoFull = 1'b0;

    busWr(3'd0, 32'hFFFF_FFF7);
    rd(3'd0, 32'h3, "R1 ctrl readback");
    chk("R1 cacheEn port", 32'(cacheEn), 32'd1);
    chk("R1 badWriteFault port", 32'(badWriteFault), 32'd1);
    busWr(3'd0, 32'hB);
    rd(3'd0, 32'hA, "R2 pd clears en");
    chk("R2 cacheEn port", 32'(cacheEn), 32'd0);
    chk("R2 powerDown port", 32'(powerDown), 32'd1);
    busWr(3'd0, 32'h1);
    rd(3'd0, 32'h1, "R1 en only");

    busWr(3'd1, 32'h0);
    @(negedge clk);
    chk("R3 bit0 clear no flush", 32'(tagClrWe), 32'd0);
    rd(3'd2, 32'h1, "R3 still ready");

    busWr(3'd1, 32'h1);
    @(negedge clk);
    walkCheck("R3 sw flush");

    busWr(3'd1, 32'h1);
    rd(3'd2, 32'h0, "R5 status busy");
    repeat (DEPTH + 2) @(posedge clk);
    rd(3'd2, 32'h1, "R5 status after flush");

    busWr(3'd1, 32'h1);
    busRd(3'd1, 32'h0, "R6 stalled read data", s);
    chk("R6 stall cycles", 32'(s), 32'(DEPTH - 1));
    busRd(3'd1, 32'h0, "R6 idle read data", s);
    chk("R6 no stall idle", 32'(s), 32'd0);

    busWr(3'd1, 32'h1);
    busWr(3'd1, 32'h1);
    @(negedge clk);
    walkCheck("R7 restart");

    pulse(1'b1, 1'b1, 5);
    pulse(1'b0, 1'b1, 4);
    rd(3'd3, 32'd5, "R8 hit count");
    rd(3'd4, 32'd9, "R9 access count");
    busWr(3'd3, 32'h1234);
    rd(3'd3, 32'd0, "R8 hit cleared");
    rd(3'd4, 32'd9, "R8 access untouched by hit clear");
    pulse(1'b1, 1'b1, 300);
    rd(3'd3, 32'd255, "R8 hit saturates");
    rd(3'd4, 32'd255, "R9 access saturates");
    busWr(3'd4, 32'h0);
    rd(3'd4, 32'd0, "R9 access cleared");
    rd(3'd3, 32'd255, "R9 hit untouched by access clear");

    chk("scoreboard drained", 32'(expData.size()), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule